// File: doc/BRIEF.md
# Dual-Channel Supply Control Register Slave on I2C

This block is a two-wire serial slave that holds the control state for two output supply channels. The host writes one data byte per transaction; the top bit of that byte picks which of two eight-bit system registers takes the remaining bits. From those registers the block decodes, for each channel, an enable, a high/low voltage choice, a one-step cable-drop boost, a forced-tone request and a high current-limit choice, plus one shared dynamic current-limit mode bit.

A read transaction returns the two register images in turn, starting with the first channel's image. Each image also carries live diagnostic flags: an overload flag per channel and a shared overtemperature flag. While the supply's power-good indication is low, the slave answers nothing and keeps every register at zero. A rising overtemperature flag wipes all writable bits.

SCL and SDA reach the block as samples already synchronous to `clk`. SDA is open-drain: the block only ever asks for the line to be pulled low.

Top module: `lnb_sysreg_i2c`

## Requirements
- R1: The slave answers the 7-bit address 000100A, where A is `addr_sel`, followed by a R/W bit (1 = read). On a match it pulls SDA low in the acknowledge slot; on any other address it leaves SDA released for the rest of that transaction.
- R2: A written data byte with bit 7 = 0 loads the first register. Bit 6 drives `dyn_lim`. Bits 5, 4, 3, 2 and 1 drive channel 0 of `cur_hi`, `tone_force`, `cable_comp`, `sel_high` and `chan_en`, in that order. Bit 0 is ignored.
- R3: A written data byte with bit 7 = 1 loads the second register. Bits 6, 5, 4, 3 and 2 drive channel 1 of `cur_hi`, `tone_force`, `cable_comp`, `sel_high` and `chan_en`, in that order. Bits 1 and 0 are ignored. A write to either register leaves the other register unchanged.
- R4: The first data byte is acknowledged. Its decoded outputs change exactly one `clk` cycle after the cycle in which SCL is sampled low at the end of the eighth data bit. The outputs change at no other time, except through R7 and R8. Any further bytes in the same write are not acknowledged and have no effect.
- R5: On a read, the first byte is {0, first register bits 6..1, `ovld[0]`}. The second byte is {1, second register bits 6..2, `overtemp`, `ovld[1]`}. Bytes are sent MSB first. A master ACK makes the slave send the other register next. A master NACK ends the read and leaves SDA released.
- R6: After reset all decoded outputs are 0 and SDA is released.
- R7: While `pwr_ok` is low the slave never pulls SDA low and all registers read and decode as 0. When power returns, the registers stay at 0 until written.
- R8: A rising edge of `overtemp` clears every writable bit of both registers one cycle later. Writes made while the flag stays high are accepted.
- R9: The slave changes its drive on SDA only while SCL is low. START (SDA falling while SCL is high) restarts address reception at any point. STOP (SDA rising while SCL is high) releases the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL sample |
| sda_i | input | 1 | Synchronized SDA sample |
| addr_sel | input | 1 | Lowest address bit |
| pwr_ok | input | 1 | Supply power-good; low blocks the slave |
| ovld | input | 2 | Live overload flag per channel |
| overtemp | input | 1 | Live overtemperature flag |
| sda_oe | output | 1 | Pull SDA low when 1 |
| dyn_lim | output | 1 | Dynamic current-limit mode |
| cur_hi | output | 2 | High current-limit choice per channel |
| tone_force | output | 2 | Continuous tone request per channel |
| cable_comp | output | 2 | One-step cable-drop boost per channel |
| sel_high | output | 2 | High output-voltage choice per channel |
| chan_en | output | 2 | Channel enable |

## Verification
The only result tied to an exact cycle is the write commit. It is taken on the clock edge that first sees SCL low after the eighth data bit, so the outputs show the new value one cycle later. The bench samples the outputs on the falling clock edge at which it drops SCL, expecting the old value, and again on the next falling edge, expecting the new value. Acknowledge and read-data bits are driven one cycle after an SCL fall. The bench reads them only in the middle of the SCL-high phase, several cycles later. The effects of power loss and of an overtemperature rise are checked a full bus bit or more after the stimulus, once the one-cycle register update has settled.

// File: rtl/lnbc_pkg.sv
// Shared constants and types for the supply-control register slave.
// Assumes byte-wide transfers on a two-wire serial bus.
package lnbc_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int SR1_W  = 6;   // writable bits 6..1 of the first register
    localparam int SR2_W  = 5;   // writable bits 6..2 of the second register

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ACK_A,
        ST_WDATA,
        ST_W_END,
        ST_ACK_W,
        ST_RDATA,
        ST_R_ACK,
        ST_R_NEXT,
        ST_IGNORE
    } eng_state_t;
endpackage

// File: rtl/lnbc_bus_cond.sv
// Detects SCL edges and START/STOP conditions from synchronous line samples.
// Assumes scl_i/sda_i are already synchronized to clk; events are reported
// in the cycle the new sample appears.
module lnbc_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q;

    // Hold previous line samples (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Classify the current sample pair.
    always_comb begin
        scl_rise = scl_i & ~scl_q;
        scl_fall = ~scl_i & scl_q;
        start_c  = scl_i & scl_q & sda_q & ~sda_i;
        stop_c   = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/lnbc_engine.sv
// Byte-level slave protocol engine: address match, single-byte write with
// commit strobe, and alternating two-image read. Drives SDA low only via
// sda_oe, and only right after an SCL fall. Assumes pwr_ok is synchronous.
module lnbc_engine
    import lnbc_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b000100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              addr_sel,
    input  logic              sda_i,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_c,
    input  logic              stop_c,
    input  logic [BYTE_W-1:0] img1,
    input  logic [BYTE_W-1:0] img2,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    eng_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh;
    logic              rw;
    logic              sel;
    logic [BYTE_W-1:0] next_img;

    // Image sent after a master ACK: the register not sent last.
    always_comb next_img = sel ? img1 : img2;

    // Commit the received data byte at the SCL fall that opens its ACK slot.
    always_comb begin
        wr_stb  = (state == ST_W_END) && scl_fall;
        wr_data = sh;
    end

    // Protocol sequencing and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            rw     <= 1'b0;
            sel    <= 1'b0;
            sda_oe <= 1'b0;
        end else if (!pwr_ok) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_c) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop_c) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (state)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        sh <= {sh[BYTE_W-2:0], sda_i};
                        if (cnt == LAST)
                            state <= (state == ST_ADDR) ? ST_ADDR_END : ST_W_END;
                        else
                            cnt <= cnt + 1'b1;
                    end
                end
                ST_ADDR_END: begin
                    if (scl_fall) begin
                        if (sh[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel}) begin
                            sda_oe <= 1'b1;
                            rw     <= sh[0];
                            state  <= ST_ACK_A;
                        end else begin
                            state  <= ST_IGNORE;
                        end
                    end
                end
                ST_ACK_A: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            sel    <= 1'b0;
                            sh     <= img1;
                            sda_oe <= ~img1[BYTE_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                end
                ST_W_END: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b1;
                        state  <= ST_ACK_W;
                    end
                end
                ST_ACK_W: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_IGNORE;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            sda_oe <= 1'b0;
                            state  <= ST_R_ACK;
                        end else begin
                            cnt    <= cnt + 1'b1;
                            sh     <= {sh[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~sh[BYTE_W-2];
                        end
                    end
                end
                ST_R_ACK: begin
                    if (scl_rise) state <= sda_i ? ST_IGNORE : ST_R_NEXT;
                end
                ST_R_NEXT: begin
                    if (scl_fall) begin
                        sel    <= ~sel;
                        sh     <= next_img;
                        sda_oe <= ~next_img[BYTE_W-1];
                        cnt    <= '0;
                        state  <= ST_RDATA;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lnbc_regs.sv
// Two system registers with selector-steered writes, power-loss hold at zero
// and clear on a rising overtemperature flag. Builds the read images with
// live flags. Assumes flags are synchronous to clk.
module lnbc_regs
    import lnbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              overtemp,
    input  logic [1:0]        ovld,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [SR1_W-1:0]  sr1w,
    output logic [SR2_W-1:0]  sr2w,
    output logic [BYTE_W-1:0] img1,
    output logic [BYTE_W-1:0] img2
);
    logic ot_q;

    // Remember the previous overtemperature level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ot_q <= 1'b0;
        else        ot_q <= overtemp;
    end

    // Register update: power loss, then overtemperature rise, then writes.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok || (overtemp && !ot_q)) begin
            sr1w <= '0;
            sr2w <= '0;
        end else if (wr_stb) begin
            if (wr_data[BYTE_W-1]) sr2w <= wr_data[BYTE_W-2 -: SR2_W];
            else                   sr1w <= wr_data[BYTE_W-2 -: SR1_W];
        end
    end

    // Read images: selector bit, writable bits, live flags.
    always_comb begin
        img1 = {1'b0, sr1w, ovld[0]};
        img2 = {1'b1, sr2w, overtemp, ovld[1]};
    end
endmodule

// File: rtl/lnb_sysreg_i2c.sv
// Top of the supply-control register slave: bus condition detector,
// protocol engine and register file, with control bits decoded per channel.
// Assumes synchronous line samples and an external open-drain pad.
module lnb_sysreg_i2c
    import lnbc_pkg::*;
#(
    parameter logic [5:0] DEV_ADDR_HI = 6'b000100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_sel,
    input  logic       pwr_ok,
    input  logic [1:0] ovld,
    input  logic       overtemp,
    output logic       sda_oe,
    output logic       dyn_lim,
    output logic [1:0] cur_hi,
    output logic [1:0] tone_force,
    output logic [1:0] cable_comp,
    output logic [1:0] sel_high,
    output logic [1:0] chan_en
);
    logic              scl_rise, scl_fall, start_c, stop_c;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_data, img1, img2;
    logic [SR1_W-1:0]  sr1w;
    logic [SR2_W-1:0]  sr2w;

    lnbc_bus_cond u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c)
    );

    lnbc_engine #(.DEV_ADDR_HI(DEV_ADDR_HI)) u_eng (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .addr_sel(addr_sel),
        .sda_i(sda_i), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_c(start_c), .stop_c(stop_c), .img1(img1), .img2(img2),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    lnbc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .overtemp(overtemp),
        .ovld(ovld), .wr_stb(wr_stb), .wr_data(wr_data),
        .sr1w(sr1w), .sr2w(sr2w), .img1(img1), .img2(img2)
    );

    // Decode register fields onto per-channel controls (index 0 = first register).
    always_comb begin
        dyn_lim    = sr1w[5];
        cur_hi     = {sr2w[4], sr1w[4]};
        tone_force = {sr2w[3], sr1w[3]};
        cable_comp = {sr2w[2], sr1w[2]};
        sel_high   = {sr2w[1], sr1w[1]};
        chan_en    = {sr2w[0], sr1w[0]};
    end
endmodule

// File: rtl/lnbc_sva.sv
// Port-level property checker for lnb_sysreg_i2c, attached by bind.
module lnbc_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        scl_i,
    input logic        pwr_ok,
    input logic        overtemp,
    input logic        sda_oe,
    input logic [10:0] ctrl
);
    AST_SILENT_NO_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !sda_oe);  // R7

    AST_ZERO_NO_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (ctrl == '0));  // R7

    AST_OT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ok && $rose(overtemp)) |=> (ctrl == '0));  // R8

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_i));  // R9

    AST_CTRL_MOVES_ONLY_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl) |-> (!$past(scl_i) || $past(overtemp) || !$past(pwr_ok)));  // R4
endmodule

bind lnb_sysreg_i2c lnbc_sva u_sva (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .pwr_ok(pwr_ok),
    .overtemp(overtemp), .sda_oe(sda_oe),
    .ctrl({dyn_lim, cur_hi, tone_force, cable_comp, sel_high, chan_en})
);

// File: tb/sim_lnb_sysreg_i2c.sv
module sim_lnb_sysreg_i2c;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic addr_sel = 1'b0, pwr_ok = 1'b1, overtemp = 1'b0;
    logic [1:0] ovld = 2'b00;
    logic sda_oe, dyn_lim;
    logic [1:0] cur_hi, tone_force, cable_comp, sel_high, chan_en;
    logic sda_bus;
    logic [10:0] ctrl_v;

    int checks = 0, errors = 0;
    logic [5:0] m1 = '0;
    logic [4:0] m2 = '0;
    logic [10:0] snap_pre, snap_post;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;
    assign ctrl_v  = {dyn_lim, cur_hi, tone_force, cable_comp, sel_high, chan_en};

    lnb_sysreg_i2c u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .addr_sel(addr_sel), .pwr_ok(pwr_ok), .ovld(ovld), .overtemp(overtemp),
        .sda_oe(sda_oe), .dyn_lim(dyn_lim), .cur_hi(cur_hi),
        .tone_force(tone_force), .cable_comp(cable_comp),
        .sel_high(sel_high), .chan_en(chan_en)
    );

    function automatic logic [10:0] exp_ctrl(input logic [5:0] a, input logic [4:0] b);
        return {a[5], b[4], a[4], b[3], a[3], b[2], a[2], b[1], a[1], b[0], a[0]};
    endfunction

    function automatic logic [7:0] exp_img1(input logic [5:0] a, input logic [1:0] ov);
        return {1'b0, a, ov[0]};
    endfunction

    function automatic logic [7:0] exp_img2(input logic [4:0] b, input logic ot, input logic [1:0] ov);
        return {1'b1, b, ot, ov[1]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0;
            if (i == 0) begin
                snap_pre = ctrl_v;
                @(negedge clk);
                snap_post = ctrl_v;
                repeat (Q - 1) @(negedge clk);
            end else begin
                wq();
            end
        end
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = ~sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_sda = 1'b1; wq();
            m_scl = 1'b1; wq();
            b = {b[6:0], sda_bus}; wq();
            m_scl = 1'b0; wq();
        end
        m_sda = ~mack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [6:0] a7, input logic [7:0] d,
                            output logic aack, output logic dack);
        bus_start();
        write_byte({a7, 1'b0}, aack);
        dack = 1'b0;
        if (aack) write_byte(d, dack);
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] a7, output logic aack,
                           output logic [7:0] b1, output logic [7:0] b2, output logic [7:0] b3);
        bus_start();
        write_byte({a7, 1'b1}, aack);
        b1 = '0; b2 = '0; b3 = '0;
        if (aack) begin
            read_byte(1'b1, b1);
            read_byte(1'b1, b2);
            read_byte(1'b0, b3);
        end
        bus_stop();
    endtask

    task automatic model_write(input logic [7:0] d);
        if (d[7]) m2 = d[6:2];
        else      m1 = d[6:1];
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic aa, da;
        logic [7:0] r1, r2, r3, d;
        logic [6:0] a7;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 outputs after reset", ctrl_v, 11'h0);
        check("R6 sda released after reset", sda_oe, 1'b0);

        // R2 directed write of the first register, exact commit cycle (R4)
        do_write(7'b0001000, 8'b0111_1111, aa, da);
        check("R1 ack own address sel=0", aa, 1'b1);
        check("R4 data byte ack", da, 1'b1);
        check("R4 outputs unchanged in fall cycle", snap_pre, 11'h0);
        model_write(8'b0111_1111);
        check("R4 outputs updated one cycle later", snap_post, exp_ctrl(m1, m2));
        check("R2 first register decode, bit 0 ignored", ctrl_v, exp_ctrl(m1, m2));

        // R3 write second register, first must be untouched
        do_write(7'b0001000, 8'b1010_1011, aa, da);
        model_write(8'b1010_1011);
        check("R3 second register decode, first untouched", ctrl_v, exp_ctrl(m1, m2));

        // R1 address select high, wrong address
        addr_sel = 1'b1;
        do_write(7'b0001000, 8'b0000_0000, aa, da);
        check("R1 nack on other address", aa, 1'b0);
        check("R1 no effect when unaddressed", ctrl_v, exp_ctrl(m1, m2));
        do_write(7'b0001001, 8'b0010_0100, aa, da);
        check("R1 ack own address sel=1", aa, 1'b1);
        model_write(8'b0010_0100);
        check("R2 write after address change", ctrl_v, exp_ctrl(m1, m2));

        // R4 extra byte in same write is refused and ignored
        bus_start();
        write_byte({7'b0001001, 1'b0}, aa);
        write_byte(8'b0100_0010, da);
        model_write(8'b0100_0010);
        write_byte(8'b0111_1110, da);
        bus_stop();
        check("R4 second data byte not acked", da, 1'b0);
        check("R4 second data byte ignored", ctrl_v, exp_ctrl(m1, m2));

        // R5 read with live flags, alternate on ACK, release on NACK
        ovld = 2'b01;
        do_read(7'b0001001, aa, r1, r2, r3);
        check("R5 read address ack", aa, 1'b1);
        check("R5 first byte image", r1, exp_img1(m1, ovld));
        check("R5 second byte image", r2, exp_img2(m2, overtemp, ovld));
        check("R5 third byte wraps to first", r3, exp_img1(m1, ovld));
        check("R5 sda released after nack", sda_oe, 1'b0);

        // R8 overtemp rise clears; writes allowed while high
        overtemp = 1'b1;
        repeat (2) @(negedge clk);
        m1 = '0; m2 = '0;
        check("R8 overtemp rise clears", ctrl_v, 11'h0);
        do_write(7'b0001001, 8'b1111_1100, aa, da);
        model_write(8'b1111_1100);
        check("R8 write accepted while overtemp high", ctrl_v, exp_ctrl(m1, m2));
        ovld = 2'b10;
        do_read(7'b0001001, aa, r1, r2, r3);
        check("R5 second byte with overtemp flag", r2, exp_img2(m2, overtemp, ovld));
        check("R5 first byte overload flag low", r1, exp_img1(m1, ovld));
        overtemp = 1'b0;

        // R7 power loss
        do_write(7'b0001001, 8'b0111_1110, aa, da);
        model_write(8'b0111_1110);
        pwr_ok = 1'b0;
        repeat (2) @(negedge clk);
        check("R7 registers zero while power low", ctrl_v, 11'h0);
        do_write(7'b0001001, 8'b0111_1110, aa, da);
        check("R7 no ack while power low", aa, 1'b0);
        check("R7 write ignored while power low", ctrl_v, 11'h0);
        pwr_ok = 1'b1;
        m1 = '0; m2 = '0;
        repeat (2) @(negedge clk);
        check("R7 registers stay zero after power returns", ctrl_v, 11'h0);

        // Random traffic against the model (R1, R2, R3, R5, R9)
        for (int n = 0; n < 48; n++) begin
            addr_sel = 1'($urandom % 2);
            ovld = 2'($urandom % 4);
            a7 = ($urandom % 4 == 0) ? {6'b000100, ~addr_sel} : {6'b000100, addr_sel};
            d = 8'($urandom);
            if (n % 4 == 3) begin
                do_read(a7, aa, r1, r2, r3);
                check("R1 random read address", aa, a7[0] == addr_sel);
                if (aa) begin
                    check("R5 random first byte", r1, exp_img1(m1, ovld));
                    check("R5 random second byte", r2, exp_img2(m2, overtemp, ovld));
                end
            end else begin
                do_write(a7, d, aa, da);
                check("R1 random write address", aa, a7[0] == addr_sel);
                if (aa) model_write(d);
                check("R3 random decode state", ctrl_v, exp_ctrl(m1, m2));
                check("R9 bus released after stop", sda_oe, 1'b0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule